// File: doc/BRIEF.md
# SYSREF Pulse Generator

This block drives the SYSREF alignment line of a high-speed converter serial link from the link clock. It has three modes, chosen at run time. The first is a single pulse that software requests by toggling a control bit. The second is a continuous square wave with equal high and low times. The third is a gapped wave whose high time is set in whole link-clock cycles.

The period of the repeating waves is the product of two 8-bit factors, E and a multiplier. A single 16-bit phase counter serves all three modes. Mode, period and high time are captured together into a working configuration, and only at a period boundary. A change in the middle of a period therefore never cuts a wave short. A gapped high time that cannot be honoured falls back to the square-wave split.

A second output reports when the generator is producing, or is about to produce, SYSREF activity.

Top module: `sysref_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the phase counter, marks a configuration load as pending and selects the single-pulse mode. `sysref_out` and `gen_active` are 0 from the edge after reset is sampled.
- R2: Mode code 2'b01 gives a square wave with period P = `e_factor`*`mult_factor` link cycles. Each period starts with floor(P/2) high cycles followed by P−floor(P/2) low cycles, so an odd P has one more low cycle than high.
- R3: Mode code 2'b10 gives a gapped wave of period P. Each period starts with `gap_high` high cycles when 1 ≤ `gap_high` ≤ P−1.
- R4: In mode 2'b10, a `gap_high` of 0, or of P or more, gives exactly the R2 waveform, with floor(P/2) high cycles.
- R5: Mode codes 2'b00 and 2'b11 select single-pulse mode. In this mode `sysref_out` goes high for exactly one cycle. This happens after the edge that samples `sw_trig`=0, provided that edge follows a sampled 1, and that 1 followed a sampled 0 after reset. A `sw_trig` held at 1 through reset therefore needs a full 0-1-0 sequence.
- R6: A single-pulse mode request produces no further pulse until another complete 0-1-0 sequence of `sw_trig`. In modes 2'b01 and 2'b10, `sw_trig` has no effect on `sysref_out`.
- R7: The mode, P and high time are captured on the first edge after reset and then at the edge that ends a period (counter value P−1). Any input change takes effect only from there, with the counter restarting at 0 and `sysref_out` following the new setting from that cycle on.
- R8: A product E*multiplier below 2 (either factor 0, or both 1) is treated as P = 2.
- R9: `gen_active` is 1 throughout modes 2'b01 and 2'b10. In single-pulse mode it is 1 from the edge that samples the armed `sw_trig`=1 through the pulse cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00/11 single pulse, 01 square wave, 10 gapped wave |
| e_factor | input | 8 | Period factor E |
| mult_factor | input | 8 | Period multiplier |
| gap_high | input | 16 | Requested high time in gapped mode, in link cycles |
| sw_trig | input | 1 | Software control bit for the single pulse |
| sysref_out | output | 1 | SYSREF line |
| gen_active | output | 1 | Generator running or a pulse armed or in progress |

## Verification
On every cycle, the assertions check several properties. The phase counter stays below the captured period and advances by exactly one inside a period. The captured configuration changes only at a boundary. The period never drops below two. The high time stays below the period. A single pulse lasts one cycle, follows a sampled low control bit and never appears in the running modes. The exact waveform shape can only be shown by the bench scenarios. These cover the floor split for odd periods, the gapped high time against each in-range and out-of-range duty value, the clamp of tiny products, the timing of the mid-period reconfiguration and the need for a fresh toggle after reset.

// File: rtl/sysref_pkg.sv
package sysref_pkg;

    localparam int FACT_W = 8;
    localparam int PER_W  = 2 * FACT_W;
    localparam int MIN_PERIOD = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_SQUARE = 2'b01,
        MODE_GAPPED = 2'b10,
        MODE_RSVD   = 2'b11
    } sr_mode_e;

    typedef struct packed {
        sr_mode_e          mode;
        logic [PER_W-1:0]  period;
        logic [PER_W-1:0]  high;
    } sr_cfg_t;

    // Running modes keep the phase counter driving the line.
    function automatic logic is_running(input sr_mode_e m);
        return (m == MODE_SQUARE) || (m == MODE_GAPPED);
    endfunction

    function automatic logic [PER_W-1:0] clamp_period(input logic [PER_W-1:0] prod);
        return (prod < PER_W'(MIN_PERIOD)) ? PER_W'(MIN_PERIOD) : prod;
    endfunction

endpackage

// File: rtl/sysref_cfg_calc.sv
module sysref_cfg_calc
    import sysref_pkg::*;
(
    input  logic [1:0]        mode_sel,
    input  logic [FACT_W-1:0] e_factor,
    input  logic [FACT_W-1:0] mult_factor,
    input  logic [PER_W-1:0]  gap_high,
    output sr_cfg_t           cfg
);
    logic [PER_W-1:0] prod;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] half;
    logic             gap_ok;
    sr_mode_e         m;

    always_comb begin
        m      = sr_mode_e'(mode_sel);
        prod   = PER_W'(e_factor) * PER_W'(mult_factor);
        per    = clamp_period(prod);
        half   = per >> 1;
        gap_ok = (gap_high != '0) && (gap_high < per);
        cfg.mode   = m;
        cfg.period = per;
        cfg.high   = ((m == MODE_GAPPED) && gap_ok) ? gap_high : half;
    end
endmodule

// File: rtl/sysref_phase_ctr.sv
module sysref_phase_ctr
    import sysref_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sr_cfg_t          cfg_in,
    output sr_cfg_t          cfg_q,
    output logic [PER_W-1:0] cnt
);
    logic load_pend;
    logic at_end;

    assign at_end = (cnt == cfg_q.period - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            load_pend    <= 1'b1;
            cfg_q.mode   <= MODE_SINGLE;
            cfg_q.period <= PER_W'(MIN_PERIOD);
            cfg_q.high   <= PER_W'(1);
        end else if (load_pend || at_end) begin
            cnt       <= '0;
            load_pend <= 1'b0;
            cfg_q     <= cfg_in;
        end else begin
            cnt <= cnt + PER_W'(1);
        end
    end

    p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        cnt < cfg_q.period);

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> (cnt == $past(cnt) + PER_W'(1)));

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(cfg_q));

    p_period_min_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_q.period >= PER_W'(MIN_PERIOD));

    p_high_below_period_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_q.high < cfg_q.period);
endmodule

// File: rtl/sysref_oneshot.sv
module sysref_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sw_trig,
    output logic armed,
    output logic pulse
);
    logic seen_low;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            seen_low <= 1'b0;
            armed    <= 1'b0;
            pulse    <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (!sw_trig) begin
                seen_low <= 1'b1;
                if (armed) begin
                    pulse <= 1'b1;
                    armed <= 1'b0;
                end
            end else if (seen_low) begin
                armed <= 1'b1;
            end
        end
    end

    p_pulse_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    p_pulse_after_low_r5: assert property (@(posedge clk) disable iff (rst)
        pulse |-> !$past(sw_trig));

    p_no_rearm_r6: assert property (@(posedge clk) disable iff (rst)
        pulse |-> !armed);
endmodule

// File: rtl/sysref_gen.sv
module sysref_gen
    import sysref_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [FACT_W-1:0] e_factor,
    input  logic [FACT_W-1:0] mult_factor,
    input  logic [PER_W-1:0]  gap_high,
    input  logic              sw_trig,
    output logic              sysref_out,
    output logic              gen_active
);
    sr_cfg_t          cfg_next;
    sr_cfg_t          cfg_q;
    logic [PER_W-1:0] cnt;
    logic             running;
    logic             armed;
    logic             pulse;
    logic             wave;

    sysref_cfg_calc u_calc (
        .mode_sel    (mode_sel),
        .e_factor    (e_factor),
        .mult_factor (mult_factor),
        .gap_high    (gap_high),
        .cfg         (cfg_next)
    );

    sysref_phase_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_next),
        .cfg_q  (cfg_q),
        .cnt    (cnt)
    );

    assign running = is_running(cfg_q.mode);

    sysref_oneshot u_shot (
        .clk     (clk),
        .rst     (rst),
        .enable  (!running),
        .sw_trig (sw_trig),
        .armed   (armed),
        .pulse   (pulse)
    );

    assign wave       = running && (cnt < cfg_q.high);
    assign sysref_out = wave || pulse;
    assign gen_active = running || armed || pulse;

    p_no_pulse_running_r6: assert property (@(posedge clk) disable iff (rst)
        running |-> !pulse);

    p_active_covers_line_r9: assert property (@(posedge clk) disable iff (rst)
        sysref_out |-> gen_active);

    p_wave_starts_high_r2: assert property (@(posedge clk) disable iff (rst)
        (running && cnt == '0) |-> sysref_out);
endmodule

// File: tb/tb_sysref_gen.sv
module tb_sysref_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic [7:0]  e_factor = 8'd1;
    logic [7:0]  mult_factor = 8'd1;
    logic [15:0] gap_high = 16'd0;
    logic        sw_trig = 1'b0;
    logic        sysref_out;
    logic        gen_active;

    int total = 0;
    int bad = 0;
    bit done = 0;

    sysref_gen dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .e_factor(e_factor),
        .mult_factor(mult_factor), .gap_high(gap_high), .sw_trig(sw_trig),
        .sysref_out(sysref_out), .gen_active(gen_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    function automatic int per_of(input int e, input int m);
        return (e * m < 2) ? 2 : e * m;
    endfunction

    function automatic int high_of(input int md, input int p, input int d);
        if (md == 2 && d >= 1 && d <= p - 1) return d;
        return p / 2;
    endfunction

    // reset, then leave at the negedge where phase index 0 is visible
    task automatic start(input int md, input int e, input int m, input int d, input logic sw);
        @(negedge clk);
        rst = 1'b1; mode_sel = 2'(md); e_factor = 8'(e); mult_factor = 8'(m);
        gap_high = 16'(d); sw_trig = sw;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wave_check(input int md, input int e, input int m, input int d,
                              input int cycles, input string req, input bit toggle);
        int p, h;
        p = per_of(e, m);
        h = high_of(md, p, d);
        for (int i = 0; i < cycles; i++) begin
            chk(sysref_out, logic'((i % p) < h), req);
            chk(gen_active, 1'b1, "R9");
            if (toggle) sw_trig = logic'((i / 2) % 2);
            @(negedge clk);
        end
    endtask

    initial begin
        // R1: outputs low during reset
        repeat (3) @(negedge clk);
        chk(sysref_out, 1'b0, "R1");
        chk(gen_active, 1'b0, "R1");

        // R2, R8: square-wave sweep including clamped products
        for (int e = 0; e <= 3; e++)
            for (int m = 1; m <= 3; m++) begin
                start(1, e, m, 0, 1'b0);
                wave_check(1, e, m, 0, 2 * per_of(e, m), (e * m < 2) ? "R8" : "R2", 1'b0);
            end

        // R3, R4: gapped sweep over every duty value from 0 to P+1
        for (int e = 1; e <= 3; e++)
            for (int m = 1; m <= 3; m++) begin
                int p;
                p = per_of(e, m);
                for (int d = 0; d <= p + 1; d++) begin
                    start(2, e, m, d, 1'b0);
                    wave_check(2, e, m, d, 2 * p, (d >= 1 && d < p) ? "R3" : "R4", 1'b0);
                end
            end

        // R6: sw_trig toggling in running modes leaves the wave unchanged
        start(1, 3, 3, 0, 1'b0);
        wave_check(1, 3, 3, 0, 27, "R6", 1'b1);
        start(2, 2, 3, 5, 1'b0);
        wave_check(2, 2, 3, 5, 24, "R6", 1'b1);

        // R7: reconfigure mid-period (P=4 square -> P=6 gapped duty 5)
        start(1, 2, 2, 0, 1'b0);
        chk(sysref_out, 1'b1, "R7");
        @(negedge clk);
        chk(sysref_out, 1'b1, "R7");
        mode_sel = 2'b10; e_factor = 8'd3; mult_factor = 8'd2; gap_high = 16'd5;
        @(negedge clk);
        chk(sysref_out, 1'b0, "R7");
        @(negedge clk);
        chk(sysref_out, 1'b0, "R7");
        @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            chk(sysref_out, logic'((k % 6) < 5), "R7");
            @(negedge clk);
        end

        // R5, R9: single pulse from a clean 0-1-0 toggle, for both mode codes
        for (int md = 0; md <= 3; md += 3) begin
            start(md, 2, 2, 0, 1'b0);
            chk(gen_active, 1'b0, "R9");
            sw_trig = 1'b1;
            @(negedge clk);
            chk(gen_active, 1'b1, "R9");
            chk(sysref_out, 1'b0, "R5");
            sw_trig = 1'b0;
            @(negedge clk);
            chk(sysref_out, 1'b1, "R5");
            chk(gen_active, 1'b1, "R9");
            @(negedge clk);
            chk(sysref_out, 1'b0, "R5");
            chk(gen_active, 1'b0, "R9");
            // R6: no further pulse while idle at 0
            for (int k = 0; k < 6; k++) begin
                chk(sysref_out, 1'b0, "R6");
                @(negedge clk);
            end
            // a second full toggle gives a second pulse
            sw_trig = 1'b1;
            @(negedge clk);
            sw_trig = 1'b0;
            @(negedge clk);
            chk(sysref_out, 1'b1, "R5");
            @(negedge clk);
            chk(sysref_out, 1'b0, "R5");
        end

        // R5: control bit held high through reset needs a full 0-1-0
        start(0, 2, 2, 0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            chk(sysref_out, 1'b0, "R5");
            @(negedge clk);
        end
        sw_trig = 1'b0;
        @(negedge clk);
        chk(sysref_out, 1'b0, "R5");
        @(negedge clk);
        chk(sysref_out, 1'b0, "R5");
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        @(negedge clk);
        chk(sysref_out, 1'b1, "R5");

        // R1: mid-run reset drives the line low
        start(1, 3, 3, 0, 1'b0);
        chk(sysref_out, 1'b1, "R2");
        rst = 1'b1;
        @(negedge clk);
        chk(sysref_out, 1'b0, "R1");
        chk(gen_active, 1'b0, "R1");
        rst = 1'b0;

        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule